// File: doc/BRIEF.md
# Received Packet Length Checker

This block sits on the receive path of a serial link's transaction layer and checks each incoming packet for length errors. It takes the fields it needs from the header: the format/type byte, the 10-bit Length field, the digest-present flag and the targeted function number. It then counts the data doublewords that follow the header. When the end-of-packet strobe arrives it delivers a verdict: either the packet is well formed or it is malformed by length.

There are two checks. The first compares the declared length with the maximum payload size that applies to the packet. That limit is chosen from the per-function settings, and the selection depends on whether the device uses alternative routing-ID numbering and on whether the settings agree across functions. The second check compares the declared length with the number of doublewords that actually arrived, leaving out the trailing digest doubleword. Each malformed verdict also raises a single-cycle error-report pulse for the receiving port.

Top module: `rx_pkt_len_chk`

## Requirements
- R1: An encoded Length of 0 stands for 1024 doublewords; any other value N stands for N doublewords.
- R2: A packet with data that is not a message is malformed when its decoded Length exceeds the selected limit, and is not malformed by this rule when the Length equals the limit. Each function has a 3-bit size code at bits [3k+2:3k] of `mps_i`. A code c from 0 to 5 gives a limit of 32<<c doublewords, and codes 6 and 7 act as 5.
- R3: A packet with data is malformed when the number of `dw_valid_i` beats between its header and its end differs from the decoded Length plus one when `digest_i` is set. The digest doubleword is never counted in the Length.
- R4: When `ari_i` is 1, the limit comes from function 0 alone, and the settings of all other functions and the target function are ignored.
- R5: When `ari_i` is 0 and all functions hold the same code, that common code is used. When they differ, the code of the function on `fn_i` is used, or the largest code when `largest_sel_i` is 1.
- R6: A message carries data when fmt bit 1 (`fmt_type_i[6]`) is 1, and is identified by type bits [4:3] = 2'b10 (`fmt_type_i[4:3]`). A message with data is not checked against the limit, but it is still checked against the received count.
- R7: A packet with fmt bit 1 = 0 (no data) is never reported malformed, whatever its Length and beat count.
- R8: `vld_o` is high for exactly the one cycle after each cycle in which `eop_i` is high. `malformed_o` and `err_o` are high together in that cycle when the packet is malformed, and are low at all other times.
- R9: After reset, `vld_o`, `malformed_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header fields valid; starts a packet and clears the beat count |
| fmt_type_i | input | 8 | {fmt[2:0], type[4:0]} of the header |
| len_i | input | 10 | Length field, in doublewords |
| digest_i | input | 1 | Packet ends with a digest doubleword |
| fn_i | input | FN_W | Targeted function number |
| dw_valid_i | input | 1 | One data doubleword received (digest included) |
| eop_i | input | 1 | Last cycle of the packet |
| ari_i | input | 1 | Alternative routing-ID mode: limit from function 0 only |
| largest_sel_i | input | 1 | With differing settings, use the largest code instead of the target's |
| mps_i | input | NUM_FN*3 | Per-function maximum payload size codes |
| vld_o | output | 1 | Verdict valid |
| malformed_o | output | 1 | Packet malformed by length |
| err_o | output | 1 | Error-report pulse for the receiving port |

## Verification
The assertions assume a well-formed packet stream. Header fields are valid when `hdr_valid_i` is high, `hdr_valid_i` comes before or with the first data beat, `eop_i` falls on or after the last beat, and the size codes and mode inputs stay stable while a packet is in flight. The bench changes configuration only between packets and always opens a packet with a header cycle. It sends up to 1025 beats, which keeps the beat counter below saturation. Its sweeps cover every size code, both digest states, lengths at the limit and one past it, and beat counts one above and one below the correct value.

// File: rtl/rx_pkt_len_pkg.sv
package rx_pkt_len_pkg;
  localparam int LEN_W        = 10;
  localparam int MAX_LEN_DW   = 1 << LEN_W;
  localparam int CNT_W        = $clog2(MAX_LEN_DW + 2) + 1;
  localparam int MPS_W        = 3;
  localparam int MPS_TOP_CODE = 5;
  localparam int MPS_BASE_DW  = 32;

  typedef logic [CNT_W-1:0] dw_cnt_t;

  typedef struct packed {
    logic [2:0] fmt;
    logic [4:0] kind;
  } fmt_type_t;

  function automatic dw_cnt_t decode_len(input logic [LEN_W-1:0] l);
    return (l == '0) ? dw_cnt_t'(MAX_LEN_DW) : dw_cnt_t'(l);
  endfunction

  function automatic logic [MPS_W-1:0] clamp_code(input logic [MPS_W-1:0] c);
    return (c > MPS_W'(MPS_TOP_CODE)) ? MPS_W'(MPS_TOP_CODE) : c;
  endfunction

  function automatic dw_cnt_t code_to_dw(input logic [MPS_W-1:0] c);
    return dw_cnt_t'(MPS_BASE_DW) << clamp_code(c);
  endfunction
endpackage

// File: rtl/rx_pkt_len_limit_sel.sv
module rx_pkt_len_limit_sel
  import rx_pkt_len_pkg::*;
#(
  parameter int NUM_FN = 4,
  parameter int FN_W   = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ari_i,
  input  logic                    largest_sel_i,
  input  logic [NUM_FN*MPS_W-1:0] mps_i,
  input  logic [FN_W-1:0]         fn_i,
  output dw_cnt_t                 limit_dw_o
);
  logic [MPS_W-1:0] code_c [NUM_FN];
  logic [MPS_W-1:0] max_code, tgt_code, sel_code;
  logic             all_same;

  for (genvar g = 0; g < NUM_FN; g++) begin : g_code
    assign code_c[g] = clamp_code(mps_i[g*MPS_W +: MPS_W]);
  end

  always_comb begin
    all_same = 1'b1;
    max_code = code_c[0];
    tgt_code = code_c[0];
    for (int i = 0; i < NUM_FN; i++) begin
      if (code_c[i] != code_c[0]) all_same = 1'b0;
      if (code_c[i] > max_code)   max_code = code_c[i];
      if (fn_i == FN_W'(i))       tgt_code = code_c[i];
    end
  end

  always_comb begin
    if (ari_i || all_same) sel_code = code_c[0];
    else if (largest_sel_i) sel_code = max_code;
    else sel_code = tgt_code;
  end

  assign limit_dw_o = code_to_dw(sel_code);

  // R4
  ari_fn0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ari_i |-> limit_dw_o == code_to_dw(mps_i[MPS_W-1:0]));

  // R5
  largest_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ari_i && largest_sel_i) |-> limit_dw_o >= code_to_dw(mps_i[MPS_W-1:0]));

  // R5
  target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ari_i && !largest_sel_i && fn_i == '0) |-> limit_dw_o == code_to_dw(mps_i[MPS_W-1:0]));
endmodule

// File: rtl/rx_pkt_len_track.sv
module rx_pkt_len_track
  import rx_pkt_len_pkg::*;
#(
  parameter int FN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  input  logic [7:0]       fmt_type_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             digest_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic             dw_valid_i,
  output logic             has_data_o,
  output logic             is_msg_o,
  output logic [LEN_W-1:0] len_o,
  output logic             digest_o,
  output logic [FN_W-1:0]  fn_o,
  output dw_cnt_t          cnt_o
);
  localparam dw_cnt_t CNT_MAX = '1;

  fmt_type_t        ft;
  logic             has_q, msg_q, dg_q;
  logic [LEN_W-1:0] len_q;
  logic [FN_W-1:0]  fn_q;
  dw_cnt_t          cnt_q, cnt_base, cnt_nxt;
  logic             has_c, msg_c;
  logic             unused_ft;

  assign ft        = fmt_type_t'(fmt_type_i);
  assign has_c     = ft.fmt[1];
  assign msg_c     = (ft.kind[4:3] == 2'b10);
  assign unused_ft = ^{ft.fmt[2], ft.fmt[0], ft.kind[2:0]};

  assign cnt_base = hdr_valid_i ? '0 : cnt_q;
  assign cnt_nxt  = (cnt_base == CNT_MAX) ? cnt_base : cnt_base + dw_cnt_t'(dw_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      has_q <= 1'b0;
      msg_q <= 1'b0;
      dg_q  <= 1'b0;
      len_q <= '0;
      fn_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (hdr_valid_i) begin
        has_q <= has_c;
        msg_q <= msg_c;
        dg_q  <= digest_i;
        len_q <= len_i;
        fn_q  <= fn_i;
      end
    end
  end

  // header fields may arrive in the same cycle as the end of packet
  assign has_data_o = hdr_valid_i ? has_c    : has_q;
  assign is_msg_o   = hdr_valid_i ? msg_c    : msg_q;
  assign len_o      = hdr_valid_i ? len_i    : len_q;
  assign digest_o   = hdr_valid_i ? digest_i : dg_q;
  assign fn_o       = hdr_valid_i ? fn_i     : fn_q;
  assign cnt_o      = cnt_nxt;

  // R3
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !hdr_valid_i) |=> cnt_q == CNT_MAX);

  // R3
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && !dw_valid_i) |=> cnt_q == '0);
endmodule

// File: rtl/rx_pkt_len_judge.sv
module rx_pkt_len_judge
  import rx_pkt_len_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eop_i,
  input  logic             has_data_i,
  input  logic             is_msg_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             digest_i,
  input  dw_cnt_t          cnt_i,
  input  dw_cnt_t          limit_dw_i,
  output logic             vld_o,
  output logic             malformed_o,
  output logic             err_o
);
  dw_cnt_t len_dw, exp_cnt;
  logic    over, mism, bad;

  assign len_dw  = decode_len(len_i);
  assign exp_cnt = len_dw + dw_cnt_t'(digest_i);
  assign over    = has_data_i && !is_msg_i && (len_dw > limit_dw_i);
  assign mism    = has_data_i && (cnt_i != exp_cnt);
  assign bad     = over || mism;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      malformed_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      vld_o       <= eop_i;
      malformed_o <= eop_i && bad;
      err_o       <= eop_i && bad;
    end
  end

  // R8
  verdict_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(eop_i));

  // R8
  err_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (vld_o && malformed_o));

  // R2
  over_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_i && has_data_i && !is_msg_i && decode_len(len_i) > limit_dw_i) |=> malformed_o);

  // R3
  mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_i && has_data_i && cnt_i != decode_len(len_i) + dw_cnt_t'(digest_i)) |=> malformed_o);

  // R7
  nodata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_i && !has_data_i) |=> !malformed_o);
endmodule

// File: rtl/rx_pkt_len_chk.sv
module rx_pkt_len_chk
  import rx_pkt_len_pkg::*;
#(
  parameter int NUM_FN = 4,
  parameter int FN_W   = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hdr_valid_i,
  input  logic [7:0]              fmt_type_i,
  input  logic [9:0]              len_i,
  input  logic                    digest_i,
  input  logic [FN_W-1:0]         fn_i,
  input  logic                    dw_valid_i,
  input  logic                    eop_i,
  input  logic                    ari_i,
  input  logic                    largest_sel_i,
  input  logic [NUM_FN*3-1:0]     mps_i,
  output logic                    vld_o,
  output logic                    malformed_o,
  output logic                    err_o
);
  logic             has_data, is_msg, digest;
  logic [LEN_W-1:0] len;
  logic [FN_W-1:0]  fn;
  dw_cnt_t          cnt, limit_dw;

  rx_pkt_len_track #(.FN_W(FN_W)) u_track (
    .clk_i, .rst_ni, .hdr_valid_i, .fmt_type_i, .len_i, .digest_i, .fn_i, .dw_valid_i,
    .has_data_o(has_data), .is_msg_o(is_msg), .len_o(len), .digest_o(digest),
    .fn_o(fn), .cnt_o(cnt)
  );

  rx_pkt_len_limit_sel #(.NUM_FN(NUM_FN), .FN_W(FN_W)) u_limit (
    .clk_i, .rst_ni, .ari_i, .largest_sel_i, .mps_i, .fn_i(fn), .limit_dw_o(limit_dw)
  );

  rx_pkt_len_judge u_judge (
    .clk_i, .rst_ni, .eop_i, .has_data_i(has_data), .is_msg_i(is_msg), .len_i(len),
    .digest_i(digest), .cnt_i(cnt), .limit_dw_i(limit_dw),
    .vld_o, .malformed_o, .err_o
  );
endmodule

// File: tb/rx_pkt_len_chk_test.sv
module rx_pkt_len_chk_test;
  localparam int NUM_FN = 4;
  localparam int FN_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, digest = 1'b0, dw_valid = 1'b0, eop = 1'b0;
  logic ari = 1'b0, lsel = 1'b0;
  logic [7:0] fmt_type = '0;
  logic [9:0] len = '0;
  logic [FN_W-1:0] fn = '0;
  logic [NUM_FN*3-1:0] mps = '0;
  logic vld, malformed, err;

  int checks = 0;
  int errors = 0;
  int codes[NUM_FN];

  always #4 clk = ~clk;

  rx_pkt_len_chk #(.NUM_FN(NUM_FN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(hdr_valid), .fmt_type_i(fmt_type),
    .len_i(len), .digest_i(digest), .fn_i(fn), .dw_valid_i(dw_valid), .eop_i(eop),
    .ari_i(ari), .largest_sel_i(lsel), .mps_i(mps),
    .vld_o(vld), .malformed_o(malformed), .err_o(err)
  );

  localparam logic [7:0] FT_MWR   = 8'b010_00000;
  localparam logic [7:0] FT_MRD   = 8'b000_00000;
  localparam logic [7:0] FT_MSGD  = 8'b011_10000;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_codes(input int c0, input int c1, input int c2, input int c3);
    codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
    for (int k = 0; k < NUM_FN; k++) mps[k*3 +: 3] = 3'(codes[k]);
  endtask

  function automatic int code_dw(input int c);
    int cc = (c > 5) ? 5 : c;
    return 32 * (2 ** cc);
  endfunction

  function automatic int model_limit(input int f);
    int mx = 0;
    bool_same: begin end
    if (ari) return code_dw(codes[0]);
    for (int k = 0; k < NUM_FN; k++) if (code_dw(codes[k]) > mx) mx = code_dw(codes[k]);
    for (int k = 1; k < NUM_FN; k++)
      if (code_dw(codes[k]) != code_dw(codes[0])) return lsel ? mx : code_dw(codes[f]);
    return code_dw(codes[0]);
  endfunction

  task automatic send(input string req, input logic [7:0] ft, input int l, input int td,
                      input int f, input int beats);
    int lenv = (l == 0) ? 1024 : l;
    int has  = ft[6];
    int msg  = (ft[4:3] == 2'b10);
    int lim  = model_limit(f);
    int bad  = has && ((!msg && lenv > lim) || (beats != lenv + td));
    @(negedge clk);
    hdr_valid = 1'b1; fmt_type = ft; len = 10'(l); digest = 1'(td); fn = FN_W'(f);
    dw_valid = 1'b0; eop = (beats == 0);
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      hdr_valid = 1'b0; dw_valid = 1'b1; eop = (i == beats - 1);
      if (i == 0) check({req, " no early verdict"}, vld, 0);
    end
    @(negedge clk);
    hdr_valid = 1'b0; dw_valid = 1'b0; eop = 1'b0;
    check({req, " R8 vld"}, vld, 1);
    check({req, " malformed"}, malformed, bad);
    check({req, " R8 err"}, err, bad);
    @(negedge clk);
    check({req, " R8 single cycle"}, vld, 0);
    check({req, " R8 quiet"}, int'(malformed) + int'(err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_codes(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R9
    check("R9 reset vld", vld, 0);
    check("R9 reset malformed", malformed, 0);
    check("R9 reset err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 sweep every code, at and over the limit, with and without digest
    for (int c = 0; c < 8; c++) begin
      set_codes(c, c, c, c);
      for (int td = 0; td < 2; td++) begin
        int lim = code_dw(c);
        send("R2 at limit", FT_MWR, lim % 1024, td, 0, lim + td);
        if (lim < 1024) send("R2 over limit", FT_MWR, lim + 1, td, 1, lim + 1 + td);
      end
    end

    // R1 length 0 decodes to 1024
    set_codes(5, 5, 5, 5);
    send("R1 len0 full", FT_MWR, 0, 0, 0, 1024);
    send("R1 len0 short", FT_MWR, 0, 0, 0, 1023);
    set_codes(4, 4, 4, 4);
    send("R1 len0 over 512", FT_MWR, 0, 1, 2, 1025);

    // R3 count mismatch sweep
    set_codes(1, 1, 1, 1);
    for (int l = 1; l <= 6; l++)
      for (int td = 0; td < 2; td++)
        for (int d = -1; d <= 1; d++)
          send("R3 count", FT_MWR, l, td, 0, l + td + d);

    // R4 ARI uses function 0 only
    ari = 1'b1;
    set_codes(1, 5, 5, 5);
    send("R4 ari pass", FT_MWR, 64, 0, 2, 64);
    send("R4 ari over", FT_MWR, 80, 0, 2, 80);
    ari = 1'b0;
    send("R5 target fn2", FT_MWR, 80, 0, 2, 80);

    // R5 differing settings: target vs largest
    set_codes(0, 1, 2, 3);
    for (int s = 0; s < 2; s++) begin
      lsel = 1'(s);
      for (int f = 0; f < NUM_FN; f++) begin
        send("R5 at", FT_MWR, code_dw(f), 0, f, code_dw(f));
        send("R5 over", FT_MWR, code_dw(f) + 1, 0, f, code_dw(f) + 1);
      end
      send("R5 big", FT_MWR, 257, 0, 0, 257);
    end
    lsel = 1'b0;
    set_codes(2, 2, 2, 2);
    send("R5 common", FT_MWR, 129, 1, 3, 130);

    // R6 message with data skips limit but not count
    set_codes(0, 0, 0, 0);
    send("R6 msg long", FT_MSGD, 900, 0, 0, 900);
    send("R6 msg short", FT_MSGD, 900, 1, 0, 900);

    // R7 no-data packets always pass
    send("R7 read long", FT_MRD, 1000, 0, 0, 0);
    send("R7 read beats", FT_MRD, 0, 1, 1, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule